// File: doc/BRIEF.md
# Direct-Mapped Single-Word Instruction Cache

This block sits between the fetch logic of a simple in-order core and a memory port that returns one word per handshake. It keeps 256 instruction words, one word to an entry, placed by physical address. Any physical address maps to exactly one entry. A demand fetch that hits returns its word one cycle after the request. A demand fetch that misses performs one memory handshake for the requested word, writes it into its entry and returns it.

A second lookup port lets the core probe the next program counter while it is still retiring the current instruction. That probe only reports hit or miss, and returns the word on a hit. It never starts a memory access and never changes the contents of the cache.

Any store issued by the core clears every entry in one cycle. Three free-running counters are provided: hits from demand fetches, hits from early probes, and refills.

Top module: `icache_word_dm`

## Requirements
- R1: After reset `fetch_ready`, `mem_req` and `probe_valid` are low, all three counters read zero, and every entry is invalid, so the first lookup of any address misses.
- R2: A demand request (`fetch_req` high while no refill is pending) that hits raises `fetch_ready` for one cycle in the next cycle, with the stored word on `fetch_data`, and leaves `mem_req` low.
- R3: A demand miss raises `mem_req` in the next cycle with `mem_addr` equal to the request address with bits [1:0] cleared. `mem_req` and `mem_addr` stay unchanged and `fetch_ready` stays low until `mem_ack`, and any `fetch_req` seen during that wait is ignored.
- R4: In the cycle after the handshake (`mem_req` and `mem_ack` both high), `fetch_ready` is high with the `mem_rdata` of that handshake, `mem_req` is low, and a later demand fetch of the same address hits.
- R5: The entry index is address bits [9:2]. Two addresses that share those bits replace each other. Addresses with different index bits, including index 255, stay resident together.
- R6: The tag is the full physical address bits [31:10]. An address that differs from a resident one only in the top bit does not hit.
- R7: A probe (`probe_req`) sets `probe_valid` in the next cycle, with `probe_hit` and, on a hit, `probe_data`. A probe never raises `mem_req`, and a probe that misses leaves the entry unfilled.
- R8: A cycle with `store_inval` high invalidates all entries, so every lookup issued after that cycle misses until it is refilled.
- R9: When `store_inval` is high in the cycle of a refill handshake, the word is still returned on `fetch_data`, but its entry ends up invalid.
- R10: `cnt_fetch_hit` grows by one per demand hit, `cnt_probe_hit` by one per probe hit, and `cnt_refill` by one per memory handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Demand lookup strobe |
| fetch_addr | input | 32 | Physical byte address of the demand lookup |
| fetch_ready | output | 1 | Demand word valid, one-cycle pulse |
| fetch_data | output | 32 | Demand instruction word |
| probe_req | input | 1 | Early lookup strobe from the writeback state |
| probe_addr | input | 32 | Physical byte address of the early lookup |
| probe_valid | output | 1 | Early lookup result valid |
| probe_hit | output | 1 | Early lookup found the word |
| probe_data | output | 32 | Early lookup word, meaningful on hit |
| store_inval | input | 1 | Core store seen, clear the whole cache |
| mem_req | output | 1 | Refill request, held until acknowledged |
| mem_addr | output | 32 | Word-aligned refill address |
| mem_ack | input | 1 | Memory completes the refill this cycle |
| mem_rdata | input | 32 | Refill word, valid with mem_ack |
| cnt_fetch_hit | output | 32 | Demand hit counter |
| cnt_probe_hit | output | 32 | Probe hit counter |
| cnt_refill | output | 32 | Refill counter |

## Verification
The bench targets aliasing first. It fetches two addresses that share index bits, and two that differ only in bit 31. A design that compares too few tag bits would wrongly return the first word for the second address. It also issues a store in the exact cycle of a refill handshake. A design that lets the refill write win would hit on the next fetch of that address, which should miss. Stray demand requests during a refill check that the pending address holds. Probes that miss before a demand fetch expose a design that fills or counts from the probe port. A wrong counter would then drift from the bench's running tallies.

// File: rtl/icw_pkg.sv
package icw_pkg;
  // byte-offset bits of one 32-bit instruction word
  localparam int unsigned WORD_OFF_W = 2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } icw_state_t;
endpackage

// File: rtl/icw_array.sv
module icw_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [TAG_W-1:0]  a_tag,
  output logic              a_hit,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [TAG_W-1:0]  b_tag,
  output logic              b_hit,
  output logic [DATA_W-1:0] b_data
);
  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      word_q[wr_idx] <= wr_data;
    end
  end

  assign a_hit  = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign a_data = word_q[a_idx];
  assign b_hit  = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
  assign b_data = word_q[b_idx];
endmodule

// File: rtl/icw_ctrl.sv
module icw_ctrl
  import icw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              lookup_hit,
  input  logic [DATA_W-1:0] lookup_data,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              evt_dmd_hit,
  output logic              evt_fill
);
  icw_state_t st_q;

  assign evt_dmd_hit = (st_q == ST_IDLE) && fetch_req && lookup_hit;
  assign evt_fill    = (st_q == ST_FILL) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      fetch_ready <= 1'b0;
      fetch_data  <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
    end else begin
      fetch_ready <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (evt_dmd_hit) begin
            fetch_ready <= 1'b1;
            fetch_data  <= lookup_data;
          end else if (fetch_req) begin
            st_q     <= ST_FILL;
            mem_req  <= 1'b1;
            mem_addr <= {fetch_addr[ADDR_W-1:WORD_OFF_W], {WORD_OFF_W{1'b0}}};
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            st_q        <= ST_IDLE;
            mem_req     <= 1'b0;
            fetch_ready <= 1'b1;
            fetch_data  <= mem_rdata;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icw_counter.sv
module icw_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (inc) value <= value + 1'b1;
  end
endmodule

// File: rtl/icache_word_dm.sv
module icache_word_dm
  import icw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  input  logic              probe_req,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_valid,
  output logic              probe_hit,
  output logic [DATA_W-1:0] probe_data,
  input  logic              store_inval,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  cnt_fetch_hit,
  output logic [CNT_W-1:0]  cnt_probe_hit,
  output logic [CNT_W-1:0]  cnt_refill
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - WORD_OFF_W;
  localparam int unsigned N_CNT = 3;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[WORD_OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // named internal events, observed by the checker
  logic              dmd_hit_raw, probe_hit_raw;
  logic [DATA_W-1:0] dmd_word, probe_word;
  logic              evt_dmd_hit, evt_fill, evt_probe_hit;

  icw_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (store_inval),
    .wr_en   (evt_fill),
    .wr_idx  (idx_of(mem_addr)),
    .wr_tag  (tag_of(mem_addr)),
    .wr_data (mem_rdata),
    .a_idx   (idx_of(fetch_addr)),
    .a_tag   (tag_of(fetch_addr)),
    .a_hit   (dmd_hit_raw),
    .a_data  (dmd_word),
    .b_idx   (idx_of(probe_addr)),
    .b_tag   (tag_of(probe_addr)),
    .b_hit   (probe_hit_raw),
    .b_data  (probe_word)
  );

  icw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .lookup_hit  (dmd_hit_raw),
    .lookup_data (dmd_word),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .fetch_ready (fetch_ready),
    .fetch_data  (fetch_data),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .evt_dmd_hit (evt_dmd_hit),
    .evt_fill    (evt_fill)
  );

  assign evt_probe_hit = probe_req && probe_hit_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      probe_valid <= 1'b0;
      probe_hit   <= 1'b0;
      probe_data  <= '0;
    end else begin
      probe_valid <= probe_req;
      probe_hit   <= evt_probe_hit;
      probe_data  <= probe_word;
    end
  end

  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];
  assign cnt_inc = {evt_fill, evt_probe_hit, evt_dmd_hit};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    icw_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .value (cnt_val[g])
    );
  end

  assign cnt_fetch_hit = cnt_val[0];
  assign cnt_probe_hit = cnt_val[1];
  assign cnt_refill    = cnt_val[2];
endmodule

// File: rtl/icw_chk.sv
module icw_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic              fetch_ready,
  input logic [DATA_W-1:0] fetch_data,
  input logic              probe_valid,
  input logic              probe_hit,
  input logic              store_inval,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [CNT_W-1:0]  cnt_refill,
  input logic              evt_dmd_hit
);
  // R2
  dmd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dmd_hit |=> fetch_ready && !mem_req);

  // R3
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));

  // R4
  fill_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> fetch_ready && !mem_req && (fetch_data == $past(mem_rdata)));

  // R7
  probe_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(fetch_req));

  // R8
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(store_inval, 2) && probe_valid) |-> !probe_hit);

  // R10
  refill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> cnt_refill == $past(cnt_refill) + 1'b1);
endmodule

bind icache_word_dm icw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_req   (fetch_req),
  .fetch_ready (fetch_ready),
  .fetch_data  (fetch_data),
  .probe_valid (probe_valid),
  .probe_hit   (probe_hit),
  .store_inval (store_inval),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .mem_rdata   (mem_rdata),
  .cnt_refill  (cnt_refill),
  .evt_dmd_hit (evt_dmd_hit)
);

// File: tb/tb_icache_word_dm.sv
module tb_icache_word_dm;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready;
  logic [31:0] fetch_data;
  logic        probe_req = 1'b0;
  logic [31:0] probe_addr = '0;
  logic        probe_valid, probe_hit;
  logic [31:0] probe_data;
  logic        store_inval = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] cnt_fetch_hit, cnt_probe_hit, cnt_refill;

  icache_word_dm dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .probe_req(probe_req), .probe_addr(probe_addr),
    .probe_valid(probe_valid), .probe_hit(probe_hit), .probe_data(probe_data),
    .store_inval(store_inval),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cnt_fetch_hit(cnt_fetch_hit), .cnt_probe_hit(cnt_probe_hit), .cnt_refill(cnt_refill)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model: resident word address per slot, counters as integers
  logic [29:0] resident [int];
  int exp_fh = 0, exp_ph = 0, exp_rf = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic int slot(input logic [31:0] a);
    return int'((a / 4) % 256);
  endfunction

  function automatic bit model_hit(input logic [31:0] a);
    int s = slot(a);
    return resident.exists(s) && (resident[s] == a[31:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_counters();
    chk(cnt_fetch_hit == exp_fh, "R10 fetch hits", cnt_fetch_hit, exp_fh);
    chk(cnt_probe_hit == exp_ph, "R10 probe hits", cnt_probe_hit, exp_ph);
    chk(cnt_refill == exp_rf, "R10 refills", cnt_refill, exp_rf);
  endtask

  // starts and ends just after a falling edge
  task automatic do_fetch(input logic [31:0] a, input int lat, input bit inv_at_ack,
                          input bit stray, input string req);
    bit h = model_hit(a);
    logic [31:0] aligned = {a[31:2], 2'b00};
    fetch_req = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    if (h) begin
      chk(fetch_ready == 1'b1, {req, " R2 ready on hit"}, fetch_ready, 1);
      chk(fetch_data == mem_word(aligned), {req, " R2 hit word"}, fetch_data, mem_word(aligned));
      chk(mem_req == 1'b0, {req, " R2 no refill on hit"}, mem_req, 0);
      exp_fh++;
    end else begin
      chk(fetch_ready == 1'b0, {req, " R3 no ready on miss"}, fetch_ready, 0);
      chk(mem_req == 1'b1, {req, " R3 refill raised"}, mem_req, 1);
      chk(mem_addr == aligned, {req, " R3 refill addr"}, mem_addr, aligned);
      for (int k = 0; k < lat; k++) begin
        if (stray && k == 0) begin
          fetch_req = 1'b1; fetch_addr = a ^ 32'h0000_0F00;
        end
        @(negedge clk);
        fetch_req = 1'b0;
        chk(mem_req == 1'b1 && mem_addr == aligned, {req, " R3 held"}, mem_addr, aligned);
        chk(fetch_ready == 1'b0, {req, " R3 ready low while waiting"}, fetch_ready, 0);
      end
      mem_ack = 1'b1; mem_rdata = mem_word(aligned); store_inval = inv_at_ack;
      @(negedge clk);
      mem_ack = 1'b0; store_inval = 1'b0;
      chk(fetch_ready == 1'b1, {req, " R4 ready after ack"}, fetch_ready, 1);
      chk(fetch_data == mem_word(aligned), {req, " R4 refill word"}, fetch_data, mem_word(aligned));
      chk(mem_req == 1'b0, {req, " R4 request dropped"}, mem_req, 0);
      exp_rf++;
      if (inv_at_ack) resident.delete();
      else resident[slot(a)] = a[31:2];
    end
    chk_counters();
  endtask

  task automatic do_probe(input logic [31:0] a, input string req);
    bit h = model_hit(a);
    logic [31:0] aligned = {a[31:2], 2'b00};
    probe_req = 1'b1; probe_addr = a;
    @(negedge clk);
    probe_req = 1'b0;
    chk(probe_valid == 1'b1, {req, " R7 probe valid"}, probe_valid, 1);
    chk(probe_hit == h, {req, " R7 probe hit"}, probe_hit, h);
    if (h) chk(probe_data == mem_word(aligned), {req, " R7 probe word"}, probe_data, mem_word(aligned));
    chk(mem_req == 1'b0, {req, " R7 probe makes no refill"}, mem_req, 0);
    if (h) exp_ph++;
    chk_counters();
  endtask

  task automatic do_store();
    store_inval = 1'b1;
    @(negedge clk);
    store_inval = 1'b0;
    resident.delete();
    chk(fetch_ready == 1'b0, "R8 store gives no fetch output", fetch_ready, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fetch_ready == 1'b0, "R1 fetch_ready", fetch_ready, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(probe_valid == 1'b0, "R1 probe_valid", probe_valid, 0);
    chk_counters();

    do_probe(32'h0000_1000, "R1 empty probe");
    do_fetch(32'h0000_1000, 2, 0, 0, "R1 first fetch");
    do_fetch(32'h0000_1000, 0, 0, 0, "R4 refetch");
    do_probe(32'h0000_1000, "R7 probe hit");

    // R5 conflict: same bits [9:2], different upper bits
    do_fetch(32'h0000_1400, 1, 0, 0, "R5 conflict fill");
    do_fetch(32'h0000_1000, 1, 0, 0, "R5 evicted");
    // R6 differs only in bit 31
    do_probe(32'h8000_1000, "R6 top bit probe");
    do_fetch(32'h8000_1000, 0, 0, 0, "R6 top bit fetch");
    do_fetch(32'h0000_1000, 0, 0, 0, "R6 original evicted");

    // R5 distinct slots coexist, including slot 255
    for (int i = 0; i < 8; i++) do_fetch(32'h0002_0000 + 4*i, i % 3, 0, 0, "R5 seq fill");
    do_fetch(32'h0003_03FC, 2, 0, 0, "R5 slot 255 fill");
    for (int i = 0; i < 8; i++) do_fetch(32'h0002_0000 + 4*i, 0, 0, 0, "R5 seq hit");
    do_fetch(32'h0003_03FC, 0, 0, 0, "R5 slot 255 hit");
    do_probe(32'h0002_0008, "R7 probe resident");

    // R3 stray demand during a pending refill
    do_fetch(32'h0004_0040, 3, 0, 1, "R3 stray request");
    do_fetch(32'h0004_0040, 0, 0, 0, "R3 stray ignored, original kept");
    do_probe(32'h0004_0F40, "R3 stray not filled");

    // R8 store wipes everything
    do_store();
    do_probe(32'h0002_0000, "R8 after store probe");
    do_probe(32'h0003_03FC, "R8 after store probe 255");
    do_fetch(32'h0002_0004, 1, 0, 0, "R8 after store fetch");

    // R7 probe miss leaves the slot empty
    do_probe(32'h0005_0010, "R7 probe miss");
    do_probe(32'h0005_0010, "R7 probe miss again");
    do_fetch(32'h0005_0010, 1, 0, 0, "R7 demand after probe miss");

    // R9 store in the refill handshake cycle
    do_fetch(32'h0006_0020, 2, 1, 0, "R9 inval at ack");
    do_probe(32'h0006_0020, "R9 probe after collision");
    do_fetch(32'h0006_0020, 1, 0, 0, "R9 fetch after collision");
    do_fetch(32'h0006_0020, 0, 0, 0, "R9 refilled normally");

    repeat (2) @(negedge clk);
    chk_counters();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule